// File: doc/BRIEF.md
# APB4 Register Port Fan-Out Decoder

This block sits between one APB4 requester and three word-sized register targets. It takes a transfer that arrives on its single upstream completer port and routes it to exactly one of three downstream requester ports. The choice depends on the word index of the transfer address. Every request field is broadcast unchanged to all three downstream ports. Only the select of the chosen port goes high. The ready, error and read-data response of that port is returned upstream.

The path has no registers. A change on any input shows on the outputs in the same cycle, so the decoder adds no wait states. Targets are 4 bytes apart: bits [3:2] name the port and bits [1:0] are not decoded. If a selected transfer addresses no target, the decoder completes it itself with an error. When nothing is selected upstream, the upstream response is held at zero.

Top module: `apb_regfan`

## Requirements
- R1: At most one downstream select is high at any time. A downstream select is high only while the upstream select is high and the address decodes to that port.
- R2: Address word index 0, 1 and 2 (byte addresses 0x0, 0x4, 0x8) select downstream ports 0, 1 and 2. Address bits [1:0] do not change the choice.
- R3: Address, write data, write flag, enable, byte strobes and protection bits reach every downstream port with exactly the upstream values. The address is not rebased.
- R4: While a downstream port is selected, upstream ready and error equal that port's ready and error.
- R5: While a downstream port is selected, upstream read data equals that port's read data.
- R6: A selected transfer whose word index (address bits [31:2]) is 3 or more selects no downstream port. Upstream ready is then 1, error is 1 and read data is 0.
- R7: While the upstream select is low, all downstream selects are low and upstream ready, error and read data are 0.
- R8: Ready, error and read data of ports that are not selected have no effect on the upstream response.
- R9: All routing is combinational. Outputs follow inputs within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s_psel | input | 1 | Upstream select |
| s_penable | input | 1 | Upstream access phase |
| s_pwrite | input | 1 | Upstream write flag |
| s_paddr | input | 32 | Upstream byte address |
| s_pprot | input | 3 | Upstream protection bits |
| s_pwdata | input | 32 | Upstream write data |
| s_pstrb | input | 4 | Upstream byte strobes |
| s_prdata | output | 32 | Read data returned upstream |
| s_pready | output | 1 | Ready returned upstream |
| s_pslverr | output | 1 | Error returned upstream |
| m_psel | output | 3 | Per-port select |
| m_penable | output | 3 | Per-port enable copy |
| m_pwrite | output | 3 | Per-port write flag copy |
| m_paddr | output | 3x32 | Per-port address copy |
| m_pprot | output | 3x3 | Per-port protection copy |
| m_pwdata | output | 3x32 | Per-port write data copy |
| m_pstrb | output | 3x4 | Per-port strobe copy |
| m_prdata | input | 3x32 | Per-port read data |
| m_pready | input | 3 | Per-port ready |
| m_pslverr | input | 3 | Per-port error |

## Verification
The hardest case to reach is a disagreement between a non-selected port and the selected one. For example, an idle port raises ready and error while the chosen port holds them low. Only in that case does a leak from the wrong port show at the upstream response. For this reason the stimulus draws fresh random responses for every port on every transfer, instead of driving only the target. It also draws addresses near the end of the map (0xC, bits [1:0] non-zero, high address bits set). This exercises the boundary between a hit and the decoder's own error completion.

// File: rtl/apbdec_pkg.sv
package apbdec_pkg;
    localparam int unsigned ADDR_W      = 32;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned STRB_W      = DATA_W / 8;
    localparam int unsigned PROT_W      = 3;
    localparam int unsigned STRIDE_LOG2 = 2;
    localparam int unsigned IDX_W       = ADDR_W - STRIDE_LOG2;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              write;
        logic              enable;
        logic [STRB_W-1:0] strb;
        logic [PROT_W-1:0] prot;
    } req_t;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              ready;
        logic              slverr;
    } rsp_t;

    localparam rsp_t RSP_QUIET  = '{rdata: '0, ready: 1'b0, slverr: 1'b0};
    localparam rsp_t RSP_DECERR = '{rdata: '0, ready: 1'b1, slverr: 1'b1};

    function automatic logic idx_matches(input logic [IDX_W-1:0] word, input int unsigned port);
        return word == IDX_W'(port);
    endfunction
endpackage

// File: rtl/apbdec_addr_map.sv
module apbdec_addr_map
    import apbdec_pkg::*;
#(
    parameter int unsigned NPORT = 3
) (
    input  logic [IDX_W-1:0] word,
    output logic [NPORT-1:0] hit_vec,
    output logic             hit
);
    for (genvar g = 0; g < NPORT; g++) begin : g_cmp
        assign hit_vec[g] = idx_matches(word, g);
    end
    assign hit = |hit_vec;
endmodule

// File: rtl/apbdec_fanout.sv
module apbdec_fanout
    import apbdec_pkg::*;
#(
    parameter int unsigned NPORT = 3
) (
    input  logic             sel_in,
    input  req_t             req,
    input  logic [NPORT-1:0] hit_vec,
    output logic [NPORT-1:0] psel,
    output req_t [NPORT-1:0] req_out
);
    for (genvar g = 0; g < NPORT; g++) begin : g_port
        assign psel[g]    = sel_in & hit_vec[g];
        assign req_out[g] = req;
    end
endmodule

// File: rtl/apbdec_resp_mux.sv
module apbdec_resp_mux
    import apbdec_pkg::*;
#(
    parameter int unsigned NPORT = 3
) (
    input  logic             sel_in,
    input  logic             hit,
    input  logic [NPORT-1:0] hit_vec,
    input  rsp_t [NPORT-1:0] rsp_in,
    output rsp_t             rsp_out
);
    rsp_t merged;

    always_comb begin
        merged = RSP_QUIET;
        for (int i = 0; i < NPORT; i++) begin
            if (hit_vec[i]) merged = merged | rsp_in[i];
        end
    end

    always_comb begin
        if (!sel_in)   rsp_out = RSP_QUIET;
        else if (!hit) rsp_out = RSP_DECERR;
        else           rsp_out = merged;
    end
endmodule

// File: rtl/apb_regfan.sv
module apb_regfan
    import apbdec_pkg::*;
#(
    parameter int unsigned NPORT = 3
) (
    input  logic                          s_psel,
    input  logic                          s_penable,
    input  logic                          s_pwrite,
    input  logic [ADDR_W-1:0]             s_paddr,
    input  logic [PROT_W-1:0]             s_pprot,
    input  logic [DATA_W-1:0]             s_pwdata,
    input  logic [STRB_W-1:0]             s_pstrb,
    output logic [DATA_W-1:0]             s_prdata,
    output logic                          s_pready,
    output logic                          s_pslverr,
    output logic [NPORT-1:0]              m_psel,
    output logic [NPORT-1:0]              m_penable,
    output logic [NPORT-1:0]              m_pwrite,
    output logic [NPORT-1:0][ADDR_W-1:0]  m_paddr,
    output logic [NPORT-1:0][PROT_W-1:0]  m_pprot,
    output logic [NPORT-1:0][DATA_W-1:0]  m_pwdata,
    output logic [NPORT-1:0][STRB_W-1:0]  m_pstrb,
    input  logic [NPORT-1:0][DATA_W-1:0]  m_prdata,
    input  logic [NPORT-1:0]              m_pready,
    input  logic [NPORT-1:0]              m_pslverr
);
    req_t             up_req;
    req_t [NPORT-1:0] dn_req;
    rsp_t [NPORT-1:0] dn_rsp;
    rsp_t             up_rsp;
    logic [NPORT-1:0] hit_vec;
    logic             hit;

    assign up_req = '{addr: s_paddr, wdata: s_pwdata, write: s_pwrite,
                      enable: s_penable, strb: s_pstrb, prot: s_pprot};

    apbdec_addr_map #(.NPORT(NPORT)) u_map (
        .word    (s_paddr[ADDR_W-1:STRIDE_LOG2]),
        .hit_vec (hit_vec),
        .hit     (hit)
    );

    apbdec_fanout #(.NPORT(NPORT)) u_fan (
        .sel_in  (s_psel),
        .req     (up_req),
        .hit_vec (hit_vec),
        .psel    (m_psel),
        .req_out (dn_req)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_unpack
        assign m_paddr[g]   = dn_req[g].addr;
        assign m_pwdata[g]  = dn_req[g].wdata;
        assign m_pwrite[g]  = dn_req[g].write;
        assign m_penable[g] = dn_req[g].enable;
        assign m_pstrb[g]   = dn_req[g].strb;
        assign m_pprot[g]   = dn_req[g].prot;
        assign dn_rsp[g]    = '{rdata: m_prdata[g], ready: m_pready[g], slverr: m_pslverr[g]};
    end

    apbdec_resp_mux #(.NPORT(NPORT)) u_rsp (
        .sel_in  (s_psel),
        .hit     (hit),
        .hit_vec (hit_vec),
        .rsp_in  (dn_rsp),
        .rsp_out (up_rsp)
    );

    assign s_prdata  = up_rsp.rdata;
    assign s_pready  = up_rsp.ready;
    assign s_pslverr = up_rsp.slverr;
endmodule

// File: rtl/apb_regfan_chk.sv
module apb_regfan_chk
    import apbdec_pkg::*;
#(
    parameter int unsigned NPORT = 3
) (
    input logic                          s_psel,
    input logic                          s_penable,
    input logic [ADDR_W-1:0]             s_paddr,
    input logic [DATA_W-1:0]             s_pwdata,
    input logic [DATA_W-1:0]             s_prdata,
    input logic                          s_pready,
    input logic                          s_pslverr,
    input logic [NPORT-1:0]              m_psel,
    input logic [NPORT-1:0]              m_penable,
    input logic [NPORT-1:0][ADDR_W-1:0]  m_paddr,
    input logic [NPORT-1:0][DATA_W-1:0]  m_pwdata,
    input logic [NPORT-1:0][DATA_W-1:0]  m_prdata,
    input logic [NPORT-1:0]              m_pready,
    input logic [NPORT-1:0]              m_pslverr
);
    always_comb begin
        // R1
        sel_onehot_chk: assert ($onehot0(m_psel));
        // R7
        idle_quiet_chk: assert (s_psel || (m_psel == '0 && !s_pready && !s_pslverr && s_prdata == '0));
        // R6
        miss_err_chk: assert (!(s_psel && m_psel == '0) || (s_pready && s_pslverr && s_prdata == '0));
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_port_chk
        always_comb begin
            // R3
            bcast_chk: assert (m_paddr[g] == s_paddr && m_pwdata[g] == s_pwdata && m_penable[g] == s_penable);
            // R4
            rsp_mirror_chk: assert (!m_psel[g] || (s_pready == m_pready[g] && s_pslverr == m_pslverr[g]));
            // R5
            rdata_mirror_chk: assert (!m_psel[g] || s_prdata == m_prdata[g]);
        end
    end
endmodule

bind apb_regfan apb_regfan_chk #(.NPORT(NPORT)) u_chk (.*);

// File: tb/sim_apb_regfan.sv
`timescale 1ns/1ps
module sim_apb_regfan;
    localparam int N = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic s_psel, s_penable, s_pwrite;
    logic [31:0] s_paddr, s_pwdata, s_prdata;
    logic [2:0]  s_pprot;
    logic [3:0]  s_pstrb;
    logic s_pready, s_pslverr;
    logic [N-1:0] m_psel, m_penable, m_pwrite, m_pready, m_pslverr;
    logic [N-1:0][31:0] m_paddr, m_pwdata, m_prdata;
    logic [N-1:0][2:0]  m_pprot;
    logic [N-1:0][3:0]  m_pstrb;

    apb_regfan u0 (.*);

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_port(input logic [31:0] a);
        return (a[31:2] < N) ? int'(a[31:2]) : -1;
    endfunction

    task automatic drive(input bit sel, input logic [31:0] a, input bit wr, input logic [31:0] wd);
        s_psel = sel; s_penable = sel; s_pwrite = wr; s_paddr = a; s_pwdata = wd;
        s_pstrb = $urandom; s_pprot = $urandom;
    endtask

    task automatic rand_rsp();
        for (int i = 0; i < N; i++) begin
            m_prdata[i] = $urandom; m_pready[i] = $urandom; m_pslverr[i] = $urandom;
        end
    endtask

    // Full comparison against the requirements; R9: sampled 1 ns after inputs, no edge between.
    task automatic check_all();
        int p = exp_port(s_paddr);
        logic [N-1:0] esel = '0;
        logic [33:0] ersp, arsp;
        #1;
        if (s_psel && p >= 0) esel[p] = 1'b1;
        chk(m_psel == esel, "R1/R2 psel", m_psel, esel);
        for (int i = 0; i < N; i++) begin
            chk(m_paddr[i] == s_paddr && m_pwdata[i] == s_pwdata && m_pwrite[i] == s_pwrite &&
                m_penable[i] == s_penable && m_pstrb[i] == s_pstrb && m_pprot[i] == s_pprot,
                "R3 broadcast", m_paddr[i], s_paddr);
        end
        if (!s_psel)     ersp = '0;                         // R7
        else if (p < 0)  ersp = {32'h0, 1'b1, 1'b1};          // R6
        else             ersp = {m_prdata[p], m_pready[p], m_pslverr[p]}; // R4 R5 R8
        arsp = {s_prdata, s_pready, s_pslverr};
        chk(arsp == ersp, !s_psel ? "R7 idle" : (p < 0 ? "R6 unmapped" : "R4/R5/R8 response"), arsp, ersp);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed1234));
        drive(0, 0, 0, 0);
        m_prdata = '1; m_pready = '1; m_pslverr = '1;
        repeat (3) @(posedge clk);
        // R7 reset/idle state with all downstream responses high
        check_all();
        rst = 1'b0;

        // R2 R3: write to 0x4 selects port 1
        @(negedge clk); drive(1, 32'h4, 1, 32'h1234_5678); rand_rsp(); check_all();
        chk(m_psel == 3'b010, "R2 addr 0x4", m_psel, 3'b010);
        chk(m_pwdata[1] == 32'h1234_5678, "R3 wdata", m_pwdata[1], 32'h1234_5678);
        // R5: read from 0x8 returns port 2 data
        @(negedge clk); drive(1, 32'h8, 0, 0); rand_rsp();
        m_prdata[2] = 32'h89AB_CDEF; m_pready[2] = 1; m_pslverr[2] = 0;
        m_pready[0] = 0; m_pslverr[0] = 1; m_pready[1] = 0; m_pslverr[1] = 1;
        check_all();
        chk(s_prdata == 32'h89AB_CDEF, "R5 read 0x8", s_prdata, 32'h89AB_CDEF);
        chk(s_pready && !s_pslverr, "R8 others ignored", {s_pready, s_pslverr}, 2'b10);
        // R2: port 0 at 0x0 and 0x3
        @(negedge clk); drive(1, 32'h0, 0, 0); rand_rsp(); check_all();
        chk(m_psel == 3'b001, "R2 addr 0x0", m_psel, 3'b001);
        @(negedge clk); drive(1, 32'h3, 0, 0); rand_rsp(); check_all();
        chk(m_psel == 3'b001, "R2 addr 0x3", m_psel, 3'b001);
        // R6: unmapped boundary and high bits
        @(negedge clk); drive(1, 32'hC, 0, 0); m_prdata = '1; m_pready = '0; m_pslverr = '0; check_all();
        chk(s_pready && s_pslverr && s_prdata == 0, "R6 addr 0xC", {s_pready, s_pslverr}, 2'b11);
        @(negedge clk); drive(1, 32'h8000_0004, 1, 0); rand_rsp(); check_all();
        chk(m_psel == '0, "R6 high bits", m_psel, 0);
        // R9: same-time propagation after an input change without any edge
        @(negedge clk); drive(1, 32'h4, 0, 0); m_prdata[1] = 32'hA5A5_0001; #1;
        m_prdata[1] = 32'h0F0F_0F0F; #0.5;
        chk(s_prdata == 32'h0F0F_0F0F, "R9 comb", s_prdata, 32'h0F0F_0F0F);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            logic [31:0] a;
            @(negedge clk);
            case ($urandom_range(0, 3))
                0: a = $urandom;
                default: a = $urandom_range(0, 19);
            endcase
            drive($urandom_range(0, 4) != 0, a, $urandom, $urandom);
            rand_rsp();
            check_all();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule